// File: doc/BRIEF.md
# Unlock Key Sequence Decoder

This block sits beside the write path of a byte-wide nonvolatile array. It sees each byte write as one strobe that carries a 17-bit address and an 8-bit value. It looks for fixed key sequences in that stream and acts on the sequences it finds.

- A three-step key turns write protection on. It also opens a window in which the data writes that follow are let through to the array.
- A six-step key turns protection off.
- A second six-step key requests an erase of the whole array.
- A three-step key followed by a throw-away write puts the part into status-read mode.

In every other case, a write reaches the array only while protection is off. The protection flag models a nonvolatile latch. A preload input supplies the retained value while reset is held. The array itself and the program timer are outside this block. The timer reports the end of a page-load window on `load_expire`.

Every write is registered. Its result shows on the outputs in the clock cycle after its strobe: `wr_permit` and `erase_req` are one-cycle pulses, and `prot_on` and `status_mode` are levels.

Top module: `unlock_seq_decoder`

## Requirements
- R1: While reset is held, `prot_on` takes the value of `prot_preload`, and `wr_permit`, `erase_req` and `status_mode` are 0.
- R2: A write that is not part of a key sequence pulses `wr_permit` in the next cycle when protection is off, and leaves it low when protection is on.
- R3: The writes AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h set `prot_on`. Every later write is then permitted until `load_expire` closes the window.
- R4: When protection is already on, the same three-step key still opens the permit window, and `prot_on` stays 1 throughout and afterwards.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 20h@5555h clear `prot_on`.
- R6: The same six writes with 10h as the last byte pulse `erase_req` for one cycle if protection is off. If protection is on, nothing happens: no erase and no permit.
- R7: The writes AAh@5555h, 55h@2AAAh and 20h@5555h, followed by one more write of any value, set `status_mode`. That last write is not permitted. `status_mode` clears on the next write or on `load_expire`.
- R8: A write that does not match the next expected step returns the decoder to idle and is treated as a plain write (rule R2). It does not start a new sequence, even if it matches the first step.
- R9: Only address bits 14..0 are compared with 5555h and 2AAAh. Bits 16..15 are ignored, and a change in bit 14 breaks the match.
- R10: `load_expire` discards any partly received key. A sequence split across two windows has no effect, and the write that would have completed it is treated as a plain write.
- R11: Writes that advance a key sequence are consumed and never pulse `wr_permit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prot_preload | input | 1 | Retained protection value loaded while reset is held |
| wr_stb | input | 1 | One-cycle strobe that marks a byte write |
| wr_addr | input | 17 | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| load_expire | input | 1 | Pulse from the program timer when the page-load window ends |
| prot_on | output | 1 | Current protection state |
| wr_permit | output | 1 | Pulse: the write of the previous cycle may go to the array |
| erase_req | output | 1 | Pulse: full-array erase requested |
| status_mode | output | 1 | Status-read mode is active |

## Verification
The properties guard these rules on every cycle:
- a permit pulse always follows a strobe;
- while protected, a permit needs an open window;
- an erase never happens while protected;
- protection and status mode change only on a write;
- a lone window expiry leaves the decoder idle with no window.

The bench's scenarios show the rest. These are the exact byte and address values of each key, mismatches that fall back to plain writes, keys split by an expiry, addresses that differ above or at bit 14, and the preloaded reset value. Each of these depends on a specific ordering of writes that no single-cycle property captures.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int KEY_W  = 15;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  KEY_D1     = 8'hAA;
    localparam logic [7:0]  KEY_D2     = 8'h55;
    localparam logic [7:0]  CMD_LOCK   = 8'hA0;
    localparam logic [7:0]  CMD_EXT    = 8'h80;
    localparam logic [7:0]  CMD_CLR    = 8'h20;
    localparam logic [7:0]  CMD_WIPE   = 8'h10;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_X1,
        SQ_X2,
        SQ_X3,
        SQ_PEEK
    } seq_e;

    typedef struct packed {
        seq_e seq;
        logic prot;
        logic win;
        logic status;
        logic permit;
        logic erase;
    } dec_st_t;

    typedef struct packed {
        logic first;
        logic second;
        logic lock;
        logic ext;
        logic clr;
        logic wipe;
    } key_hit_t;

endpackage

// File: rtl/ulk_key_match.sv
module ulk_key_match
    import ulk_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int KW = KEY_W
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output key_hit_t      hit
);

    localparam logic [KW-1:0] ADDR_A = KW'(KEY_ADDR_A);
    localparam logic [KW-1:0] ADDR_B = KW'(KEY_ADDR_B);

    logic          at_a;
    logic          at_b;
    logic [AW-KW-1:0] unused_page_bits;

    // upper address bits take no part in key recognition
    assign unused_page_bits = addr[AW-1:KW];

    always_comb begin
        at_a       = (addr[KW-1:0] == ADDR_A);
        at_b       = (addr[KW-1:0] == ADDR_B);
        hit.first  = at_a && (data == DW'(KEY_D1));
        hit.second = at_b && (data == DW'(KEY_D2));
        hit.lock   = at_a && (data == DW'(CMD_LOCK));
        hit.ext    = at_a && (data == DW'(CMD_EXT));
        hit.clr    = at_a && (data == DW'(CMD_CLR));
        hit.wipe   = at_a && (data == DW'(CMD_WIPE));
    end

endmodule

// File: rtl/ulk_seq_fsm.sv
module ulk_seq_fsm
    import ulk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     prot_preload,
    input  logic     wr_stb,
    input  logic     load_expire,
    input  key_hit_t hit,
    output logic     prot_o,
    output logic     permit_o,
    output logic     erase_o,
    output logic     status_o
);

    dec_st_t st_d;
    dec_st_t st_q;
    dec_st_t cur;
    logic    plain;

    always_comb begin
        cur = st_q;
        if (load_expire) begin
            cur.seq    = SQ_IDLE;
            cur.win    = 1'b0;
            cur.status = 1'b0;
        end
        plain       = 1'b0;
        st_d        = cur;
        st_d.permit = 1'b0;
        st_d.erase  = 1'b0;
        if (wr_stb) begin
            st_d.status = 1'b0;
            if (cur.win) begin
                st_d.permit = 1'b1;
            end else begin
                st_d.seq = SQ_IDLE;
                case (cur.seq)
                    SQ_IDLE: if (hit.first) st_d.seq = SQ_K1; else plain = 1'b1;
                    SQ_K1:   if (hit.second) st_d.seq = SQ_K2; else plain = 1'b1;
                    SQ_K2: begin
                        if (hit.lock) begin
                            st_d.prot = 1'b1;
                            st_d.win  = 1'b1;
                        end else if (hit.ext) begin
                            st_d.seq = SQ_X1;
                        end else if (hit.clr) begin
                            st_d.seq = SQ_PEEK;
                        end else begin
                            plain = 1'b1;
                        end
                    end
                    SQ_X1:   if (hit.first) st_d.seq = SQ_X2; else plain = 1'b1;
                    SQ_X2:   if (hit.second) st_d.seq = SQ_X3; else plain = 1'b1;
                    SQ_X3: begin
                        if (hit.clr) begin
                            st_d.prot = 1'b0;
                        end else if (hit.wipe) begin
                            st_d.erase = !cur.prot;
                        end else begin
                            plain = 1'b1;
                        end
                    end
                    SQ_PEEK: st_d.status = 1'b1;
                    default: plain = 1'b1;
                endcase
                if (plain) begin
                    st_d.permit = !cur.prot;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prot <= prot_preload;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_o   = st_q.prot;
    assign permit_o = st_q.permit;
    assign erase_o  = st_q.erase;
    assign status_o = st_q.status;

    AST_PERMIT_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.permit |-> $past(wr_stb)); // R2

    AST_LOCKED_PERMIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.permit && $past(st_q.prot)) |-> $past(st_q.win)); // R4

    AST_ERASE_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.erase |-> (!st_q.prot && !$past(st_q.prot) && !st_q.permit)); // R6

    AST_PROT_MOVES_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.prot) |-> $past(wr_stb)); // R3

    AST_STATUS_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.status) |-> $past(wr_stb)); // R7

    AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_expire && !wr_stb) |=> (!st_q.win && !st_q.status && st_q.seq == SQ_IDLE)); // R10

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import ulk_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int KW = KEY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prot_preload,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          load_expire,
    output logic          prot_on,
    output logic          wr_permit,
    output logic          erase_req,
    output logic          status_mode
);

    key_hit_t hit;

    ulk_key_match #(
        .AW (AW),
        .DW (DW),
        .KW (KW)
    ) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    ulk_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .prot_preload (prot_preload),
        .wr_stb       (wr_stb),
        .load_expire  (load_expire),
        .hit          (hit),
        .prot_o       (prot_on),
        .permit_o     (wr_permit),
        .erase_o      (erase_req),
        .status_o     (status_mode)
    );

endmodule

// File: tb/unlock_seq_decoder_test.sv
`timescale 1ns/1ps
module unlock_seq_decoder_test;

    localparam logic [16:0] A5 = 17'h05555;
    localparam logic [16:0] A2 = 17'h02AAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_preload = 1'b0;
    logic        wr_stb = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_expire = 1'b0;
    logic        prot_on, wr_permit, erase_req, status_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    unlock_seq_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .prot_preload (prot_preload),
        .wr_stb       (wr_stb),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .load_expire  (load_expire),
        .prot_on      (prot_on),
        .wr_permit    (wr_permit),
        .erase_req    (erase_req),
        .status_mode  (status_mode)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: queue the expected {permit,erase,prot,status}, then strobe
    task automatic wr(input logic [16:0] a, input logic [7:0] d,
                      input logic ep, input logic ee, input logic epr,
                      input logic es, input string tag);
        exp_q.push_back({ep, ee, epr, es});
        tag_q.push_back(tag);
        @(negedge clk);
        wr_addr = a;
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic expire();
        @(negedge clk);
        load_expire = 1'b1;
        @(negedge clk);
        load_expire = 1'b0;
    endtask

    task automatic do_reset(input logic pre);
        @(negedge clk);
        rst_n = 1'b0;
        prot_preload = pre;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: compare one expected item per strobe one cycle later
    initial begin
        forever begin
            @(posedge clk);
            if (wr_stb === 1'b1 && rst_n === 1'b1) begin
                @(negedge clk);
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: actual=write expected=none");
                end else begin
                    logic [3:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({wr_permit, erase_req, prot_on, status_mode} !== e) begin
                        errors++;
                        $display("FAIL %s: {permit,erase,prot,status} actual=%b expected=%b",
                                 t, {wr_permit, erase_req, prot_on, status_mode}, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        chk(prot_on, 1'b0, "R1 prot");
        chk(wr_permit, 1'b0, "R1 permit");
        chk(erase_req, 1'b0, "R1 erase");
        chk(status_mode, 1'b0, "R1 status");

        wr(17'h00123, 8'h5A, 1, 0, 0, 0, "R2 plain unprotected");

        wr(A5, 8'hAA, 0, 0, 0, 0, "R11 key step 1");
        wr(A2, 8'h55, 0, 0, 0, 0, "R11 key step 2");
        wr(A5, 8'hA0, 0, 0, 1, 0, "R3 enable");
        wr(17'h00400, 8'h11, 1, 0, 1, 0, "R3 window write");
        wr(17'h00401, 8'h22, 1, 0, 1, 0, "R3 window write");
        expire();
        chk(prot_on, 1'b1, "R3 prot after expire");
        wr(17'h00402, 8'h33, 0, 0, 1, 0, "R2 plain blocked");

        wr(A5, 8'hAA, 0, 0, 1, 0, "R6");
        wr(A2, 8'h55, 0, 0, 1, 0, "R6");
        wr(A5, 8'h80, 0, 0, 1, 0, "R6");
        wr(A5, 8'hAA, 0, 0, 1, 0, "R6");
        wr(A2, 8'h55, 0, 0, 1, 0, "R6");
        wr(A5, 8'h10, 0, 0, 1, 0, "R6 erase ignored when protected");

        wr(A5, 8'hAA, 0, 0, 1, 0, "R7");
        wr(A2, 8'h55, 0, 0, 1, 0, "R7");
        wr(A5, 8'h20, 0, 0, 1, 0, "R7");
        wr(17'h00000, 8'h00, 0, 0, 1, 1, "R7 dummy write");
        wr(17'h00010, 8'h44, 0, 0, 1, 0, "R7 mode ends on write");

        wr(A5, 8'hAA, 0, 0, 1, 0, "R8");
        wr(17'h00100, 8'h12, 0, 0, 1, 0, "R8 mismatch blocked");
        wr(A5, 8'hAA, 0, 0, 1, 0, "R8");
        wr(A5, 8'hAA, 0, 0, 1, 0, "R8 no restart");
        wr(A2, 8'h55, 0, 0, 1, 0, "R8 plain");
        wr(A5, 8'hA0, 0, 0, 1, 0, "R8 plain");
        wr(17'h00050, 8'h66, 0, 0, 1, 0, "R8 no window opened");

        wr(17'h15555, 8'hAA, 0, 0, 1, 0, "R9 high bits ignored");
        wr(17'h12AAA, 8'h55, 0, 0, 1, 0, "R9 high bits ignored");
        wr(17'h1D555, 8'hA0, 0, 0, 1, 0, "R9 high bits ignored");
        wr(17'h1C000, 8'h77, 1, 0, 1, 0, "R4 protected write");
        expire();
        chk(prot_on, 1'b1, "R4 stays protected");
        wr(17'h01555, 8'hAA, 0, 0, 1, 0, "R9 bit14 mismatch");

        wr(A5, 8'hAA, 0, 0, 1, 0, "R5");
        wr(A2, 8'h55, 0, 0, 1, 0, "R5");
        wr(A5, 8'h80, 0, 0, 1, 0, "R5");
        wr(A5, 8'hAA, 0, 0, 1, 0, "R5");
        wr(A2, 8'h55, 0, 0, 1, 0, "R5");
        wr(A5, 8'h20, 0, 0, 0, 0, "R5 disable");
        wr(17'h00300, 8'h88, 1, 0, 0, 0, "R5 plain allowed");

        wr(A5, 8'hAA, 0, 0, 0, 0, "R8");
        wr(17'h00200, 8'h33, 1, 0, 0, 0, "R8 mismatch permitted");

        wr(A5, 8'hAA, 0, 0, 0, 0, "R10");
        wr(A2, 8'h55, 0, 0, 0, 0, "R10");
        expire();
        wr(A5, 8'hA0, 1, 0, 0, 0, "R10 split key is plain");

        wr(A5, 8'hAA, 0, 0, 0, 0, "R6");
        wr(A2, 8'h55, 0, 0, 0, 0, "R6");
        wr(A5, 8'h80, 0, 0, 0, 0, "R6");
        wr(A5, 8'hAA, 0, 0, 0, 0, "R6");
        wr(A2, 8'h55, 0, 0, 0, 0, "R6");
        wr(A5, 8'h10, 0, 1, 0, 0, "R6 erase");
        @(negedge clk);
        chk(erase_req, 1'b0, "R6 erase one cycle");

        wr(A5, 8'hAA, 0, 0, 0, 0, "R7");
        wr(A2, 8'h55, 0, 0, 0, 0, "R7");
        wr(A5, 8'h20, 0, 0, 0, 0, "R7");
        wr(17'h00ABC, 8'hFF, 0, 0, 0, 1, "R7 status unprotected");
        expire();
        chk(status_mode, 1'b0, "R7 cleared by expire");

        do_reset(1'b1);
        chk(prot_on, 1'b1, "R1 preload prot");
        chk(wr_permit, 1'b0, "R1 permit");
        chk(status_mode, 1'b0, "R1 status");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, 1'b1, "R2 scoreboard drained");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule